// File: doc/BRIEF.md
# Time-Interleaved Add-and-Compare Datapath

This block takes one operand set per clock cycle (two addends and a threshold) and produces, for each set, the full-width sum of the addends and a flag telling whether that sum is strictly greater than the threshold. The work is spread over `LANES` identical copies of the adder-plus-comparator logic. Incoming sets are handed to the copies in strict rotation, so each copy accepts a new set only once every `LANES` cycles. The logic inside each copy therefore has `LANES` cycles to settle, and each copy path can be constrained as a multicycle path. That slack is what would let the copies run at a reduced supply or with slower cells.

A free-running phase counter produces one load strobe per copy, standing in for a set of staggered slow clocks. It also drives the select of a full-rate multiplexer, which rebuilds a single result stream in arrival order. Everything runs on one clock. Results come out with a fixed latency of `LANES + 1` clock edges after the edge that accepts the operands. The block assumes `LANES >= 2`.

Top module: `interleaved_addcmp`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `out_valid`, `out_sum` and `out_gt` are all 0 after that edge.
- R2: For an accepted set, `out_sum` equals `in_a + in_b` as an unsigned `WIDTH+1`-bit value, with no wraparound; the top bit holds the carry.
- R3: `out_gt` is 1 exactly when that `WIDTH+1`-bit sum is strictly greater than `in_c` zero-extended; a sum equal to `in_c` gives 0.
- R4: A set sampled with `in_valid` high at rising edge e appears on the outputs, with `out_valid` high, in the cycle after edge e + `LANES` + 1.
- R5: Results leave in the order the sets arrived. A run of back-to-back valid inputs yields a run of back-to-back valid outputs of the same length.
- R6: A cycle with `in_valid` low at edge e yields `out_valid` low in the cycle after edge e + `LANES` + 1.
- R7: The phase counter steps from 0 to `LANES`-1 and wraps, one step per cycle, whatever `in_valid` does. In phase k only copy k loads its operands. Each copy therefore holds its operands for `LANES` cycles, and the load strobe rotates by one copy each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all copies, the phase counter and the output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the operand set on this cycle as real |
| in_a | input | WIDTH | First addend |
| in_b | input | WIDTH | Second addend |
| in_c | input | WIDTH | Threshold compared against the sum |
| out_valid | output | 1 | Marks the result on this cycle as real |
| out_sum | output | WIDTH+1 | Full-width sum of the addends |
| out_gt | output | 1 | 1 when the sum exceeds the threshold |

## Verification
The bench builds two instances with `WIDTH` = 8, one with `LANES` = 2 and one with `LANES` = 4, and drives both from the same stimulus. The two-copy instance covers the even/odd alternation with a power-of-two counter wrap. The four-copy instance reaches the longer latency, a wider multiplexer select and a rotation in which a copy sits idle for three cycles between loads. Both are compared against a single-copy reference with the latency of each instance. The stimulus covers carry-out sums, sums equal to the threshold, one-off-either-side thresholds, gapped streams and long back-to-back runs.

// File: rtl/iv_pkg.sv
// Package iv_pkg
// Shared helpers for the interleaved add-and-compare datapath.
// Assumes: callers pass a lane count of at least 1.
package iv_pkg;

    // Width of a counter that indexes n lanes; never less than one bit.
    function automatic int unsigned iv_ptr_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/iv_phase_gen.sv
// Module iv_phase_gen
// Free-running phase counter that stands in for a staggered multiphase clock.
// It produces one load strobe per lane and the index of the lane whose
// result was registered at the previous edge.
// Assumes: LANES >= 2 and PW wide enough to hold LANES-1.
module iv_phase_gen #(
    parameter int unsigned LANES = 2,
    parameter int unsigned PW    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PW-1:0]    phase,
    output logic [LANES-1:0] load_en,
    output logic [PW-1:0]    ready_lane
);
    localparam logic [PW-1:0] LAST = PW'(LANES - 1);

    // Step the phase once per cycle and wrap after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // Decode one load strobe per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_strobe
        assign load_en[k] = (phase == PW'(k));
    end

    // The lane loaded at the previous edge is the one whose result is fresh.
    always_comb ready_lane = (phase == '0) ? LAST : (phase - 1'b1);

endmodule

// File: rtl/iv_lane.sv
// Module iv_lane
// One slow copy of the reference computation: operand register, adder with
// carry-out, greater-than comparator and result register. Both registers
// update only on the lane's load strobe, so the logic between them has a
// full rotation of the phase counter to settle.
// Assumes: load is asserted once every LANES cycles.
module iv_lane #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_v,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic             res_v,
    output logic [WIDTH:0]   res_sum,
    output logic             res_gt
);
    logic             v_q;
    logic [WIDTH-1:0] a_q, b_q, c_q;
    logic [WIDTH:0]   sum_w;
    logic             gt_w;

    // Multicycle path: sum with carry, then unsigned compare with the threshold.
    always_comb begin
        sum_w = {1'b0, a_q} + {1'b0, b_q};
        gt_w  = sum_w > {1'b0, c_q};
    end

    // On the strobe, retire the settled result and take the next operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= 1'b0;
            a_q     <= '0;
            b_q     <= '0;
            c_q     <= '0;
            res_v   <= 1'b0;
            res_sum <= '0;
            res_gt  <= 1'b0;
        end else if (load) begin
            res_v   <= v_q;
            res_sum <= sum_w;
            res_gt  <= gt_w;
            v_q     <= in_v;
            a_q     <= a;
            b_q     <= b;
            c_q     <= c;
        end
    end

endmodule

// File: rtl/iv_merge.sv
// Module iv_merge
// Full-rate N-to-1 recombiner: registers the result of the lane named by sel
// every cycle, which rebuilds the stream in arrival order.
// Assumes: sel always names a lane below LANES.
module iv_merge #(
    parameter int unsigned LANES = 2,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned PW    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PW-1:0]               sel,
    input  logic [LANES-1:0]            lane_v,
    input  logic [LANES-1:0][WIDTH:0]   lane_sum,
    input  logic [LANES-1:0]            lane_gt,
    output logic                        out_v,
    output logic [WIDTH:0]              out_sum,
    output logic                        out_gt
);
    // Capture the selected lane into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v   <= 1'b0;
            out_sum <= '0;
            out_gt  <= 1'b0;
        end else begin
            out_v   <= lane_v[sel];
            out_sum <= lane_sum[sel];
            out_gt  <= lane_gt[sel];
        end
    end

endmodule

// File: rtl/interleaved_addcmp.sv
// Module interleaved_addcmp
// Time-interleaved add-and-compare datapath: operand sets arrive one per
// cycle, are dealt round-robin to LANES slow copies, and are recombined by
// a full-rate multiplexer. Latency is LANES+1 edges from acceptance.
// Assumes: LANES >= 2; single clock; synchronous active-low reset.
module interleaved_addcmp #(
    parameter int unsigned LANES = 2,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic             out_valid,
    output logic [WIDTH:0]   out_sum,
    output logic             out_gt
);
    localparam int unsigned PW = iv_pkg::iv_ptr_w(LANES);

    logic [PW-1:0]              phase;
    logic [PW-1:0]              ready_lane;
    logic [LANES-1:0]           load_en;
    logic [LANES-1:0]           lane_v;
    logic [LANES-1:0][WIDTH:0]  lane_sum;
    logic [LANES-1:0]           lane_gt;

    iv_phase_gen #(.LANES(LANES), .PW(PW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .load_en    (load_en),
        .ready_lane (ready_lane)
    );

    // One slow copy per lane, each fed by its own strobe.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        iv_lane #(.WIDTH(WIDTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_en[k]),
            .in_v    (in_valid),
            .a       (in_a),
            .b       (in_b),
            .c       (in_c),
            .res_v   (lane_v[k]),
            .res_sum (lane_sum[k]),
            .res_gt  (lane_gt[k])
        );
    end

    iv_merge #(.LANES(LANES), .WIDTH(WIDTH), .PW(PW)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (ready_lane),
        .lane_v   (lane_v),
        .lane_sum (lane_sum),
        .lane_gt  (lane_gt),
        .out_v    (out_valid),
        .out_sum  (out_sum),
        .out_gt   (out_gt)
    );

endmodule

// File: rtl/iv_chk.sv
// Module iv_chk
// Property checker for interleaved_addcmp, attached with bind. It keeps a
// single-copy reference delay line of LANES+1 stages and compares the
// outputs against it, and it checks the rotation of the load strobes.
// Assumes: LANES >= 2.
module iv_chk #(
    parameter int unsigned LANES = 2,
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic [WIDTH-1:0] in_c,
    input logic             out_valid,
    input logic [WIDTH:0]   out_sum,
    input logic             out_gt,
    input logic [LANES-1:0] load_en
);
    localparam int unsigned LAT = LANES + 1;

    logic [LAT:0]          dv;
    logic [LAT:0][WIDTH:0] ds;
    logic [LAT:0]          dg;
    logic [WIDTH:0]        ref_sum;

    // Reference result of the current operands, computed in one step.
    always_comb ref_sum = {1'b0, in_a} + {1'b0, in_b};

    // Delay the reference by the block's latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv <= '0;
            ds <= '0;
            dg <= '0;
        end else begin
            dv <= {dv[LAT-1:0], in_valid};
            ds <= {ds[LAT-1:0], ref_sum};
            dg <= {dg[LAT-1:0], (ref_sum > {1'b0, in_c})};
        end
    end

    // R4 and R6: output valid follows input valid after the fixed latency.
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == dv[LAT]);

    // R2: full-width sum with carry, in arrival order (R5).
    a_r2_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == ds[LAT]);

    // R3: strict compare on the carry-extended sum.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_gt == dg[LAT]);

    // R7: the load strobe moves to the next lane every cycle.
    a_r7_strobe_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> load_en == {$past(load_en[LANES-2:0]), $past(load_en[LANES-1])});

    // R7: exactly one lane loads in each cycle.
    a_r7_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(load_en) == 1);

endmodule

bind interleaved_addcmp iv_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_gt    (out_gt),
    .load_en   (load_en)
);

// File: tb/interleaved_addcmp_tb.sv
`timescale 1ns/1ps
// Bench for interleaved_addcmp: two instances (two and four lanes) share one
// stimulus stream; a driver task queues expected items, monitors pop them.
module interleaved_addcmp_tb;
    localparam int unsigned W = 8;

    typedef struct packed {
        logic         v;
        logic [W:0]   s;
        logic         g;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
    logic o2_v, o2_g, o4_v, o4_g;
    logic [W:0] o2_s, o4_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q2[$];
    exp_t q4[$];

    always #2.5 clk = ~clk;

    interleaved_addcmp #(.LANES(2), .WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .out_valid(o2_v), .out_sum(o2_s), .out_gt(o2_g));

    interleaved_addcmp #(.LANES(4), .WIDTH(W)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .out_valid(o4_v), .out_sum(o4_s), .out_gt(o4_g));

    // Drive one operand set and queue its expected result for both instances.
    task automatic drive(input logic v, input logic [W-1:0] a, b, c);
        exp_t e;
        @(negedge clk);
        #1;
        in_valid = v; in_a = a; in_b = b; in_c = c;
        e.v = v;
        e.s = {1'b0, a} + {1'b0, b};
        e.g = e.s > {1'b0, c};
        q2.push_back(e);
        q4.push_back(e);
    endtask

    // Compare one output cycle against the expected item.
    task automatic check_item(input string who, input exp_t e,
                              input logic v, input logic [W:0] s, input logic g);
        checks++;
        if (v !== e.v) begin
            fails++;
            $display("FAIL %s %s valid: got %b expected %b", who,
                     e.v ? "R4" : "R6", v, e.v);
        end
        if (e.v) begin
            checks++;
            if (s !== e.s) begin
                fails++;
                $display("FAIL %s R2/R5/R7 sum: got %0d expected %0d", who, s, e.s);
            end
            checks++;
            if (g !== e.g) begin
                fails++;
                $display("FAIL %s R3 gt: got %b expected %b", who, g, e.g);
            end
        end
    endtask

    // Monitor for the two-lane instance: latency of 3 edges.
    always @(negedge clk) begin
        if (rst_n && q2.size() > 3) check_item("L2", q2.pop_front(), o2_v, o2_s, o2_g);
    end

    // Monitor for the four-lane instance: latency of 5 edges.
    always @(negedge clk) begin
        if (rst_n && q4.size() > 5) check_item("L4", q4.pop_front(), o4_v, o4_s, o4_g);
    end

    // Check a reset-state value.
    task automatic check_rst(input string what, input int got);
        checks++;
        if (got != 0) begin
            fails++;
            $display("FAIL R1 %s after reset: got %0d expected 0", what, got);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs cleared by the synchronous reset.
        check_rst("L2 out_valid", int'(o2_v));
        check_rst("L2 out_sum",   int'(o2_s));
        check_rst("L2 out_gt",    int'(o2_g));
        check_rst("L4 out_valid", int'(o4_v));
        check_rst("L4 out_sum",   int'(o4_s));
        check_rst("L4 out_gt",    int'(o4_g));
        rst_n = 1'b1;

        // R2/R3 corners: carry out, equal-to-threshold, one off either side.
        drive(1, 8'd255, 8'd255, 8'd255);
        drive(1, 8'd0,   8'd0,   8'd0);
        drive(1, 8'd100, 8'd28,  8'd128);
        drive(1, 8'd100, 8'd28,  8'd127);
        drive(1, 8'd200, 8'd100, 8'd255);
        drive(1, 8'd1,   8'd255, 8'd0);
        drive(1, 8'd0,   8'd0,   8'd1);
        drive(1, 8'd128, 8'd127, 8'd255);

        // R6: alternating and sparse gaps.
        for (int i = 0; i < 40; i++)
            drive(logic'(i % 2), 8'($urandom), 8'($urandom), 8'($urandom));
        for (int i = 0; i < 200; i++)
            drive(logic'(($urandom % 3) != 0), 8'($urandom), 8'($urandom), 8'($urandom));

        // R5/R7: long back-to-back run at the full input rate.
        for (int i = 0; i < 400; i++)
            drive(1, 8'($urandom), 8'($urandom), 8'($urandom));

        // Drain the pipelines with empty slots.
        for (int i = 0; i < 8; i++) drive(0, '0, '0, '0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule